// File: doc/BRIEF.md
# Frequent Pattern Line Codec

This block shrinks a 64-byte cache line by treating it as sixteen unrelated 32-bit words. Every word is tested against a handful of common value shapes (zero, small signed numbers, half-words with a zero lower half, paired sign-extended bytes, a single byte repeated). It is then replaced by a 3-bit code plus only the bits that the code cannot regenerate. The codes and the kept bits are packed into one bitstream, and the size of that stream is reported as a number of 8-byte segments. When packing would save less than one segment, the line is flagged as uncompressed and passed on verbatim.

A second, independent path takes a packed line and its uncompressed flag and rebuilds the original 64 bytes through a fixed five-stage pipeline. Both paths use valid/ready handshakes on their inputs and outputs, and they can run in the same cycles without affecting each other.

Top module: `fpc_line_codec`

## Requirements
- R1: Word codes are: 0 all-zero (no kept bits); 1 value equal to the sign extension of its low 4 bits (keeps bits 3:0); 2 sign extension of its low 8 bits (keeps 7:0); 3 sign extension of its low 16 bits (keeps 15:0); 4 low half zero (keeps 31:16); 5 each half equal to the sign extension of its own low byte (keeps byte 2 as payload bits 15:8 and byte 0 as bits 7:0); 6 all four bytes equal (keeps 7:0); 7 anything else (keeps all 32 bits).
- R2: Where several codes fit a word, the code with the fewest kept bits is used, and among equals the smaller code value is used.
- R3: The packed stream holds the code of word i at bits 3i+2..3i. The kept bits follow from bit 48, word 0 first, each word's field placed LSB first with no gaps. All bits after the last field are zero.
- R4: For a packed line, the segment count is the stream length in bits (48 plus all kept bits), divided by 64 and rounded up.
- R5: When the stream would exceed 448 bits, the output flag reads 1, the data equals the input line unchanged, and the segment count is 8. Otherwise the flag reads 0.
- R6: The expander returns the original line bit-exactly. The result is valid after the fifth rising edge, counting the edge that accepted the input.
- R7: An expander input marked uncompressed is returned unchanged.
- R8: While an output is valid and not taken, it stays valid with stable contents and its path accepts no new input; no accepted line is lost.
- R9: After reset both output valids are low and both input readies are high.
- R10: The compress and expand paths accept and deliver lines in the same cycles without interfering, at one line per cycle when their outputs are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cin_valid | input | 1 | Line to compress is present |
| cin_ready | output | 1 | Compress path can accept |
| cin_line | input | 512 | Line to compress |
| cout_valid | output | 1 | Packed result present |
| cout_ready | input | 1 | Packed result taken |
| cout_data | output | 512 | Packed stream or raw line |
| cout_segs | output | 4 | Size in 8-byte segments |
| cout_raw | output | 1 | Line stored uncompressed |
| din_valid | input | 1 | Packed line to expand present |
| din_ready | output | 1 | Expand path can accept |
| din_data | input | 512 | Packed stream or raw line |
| din_raw | input | 1 | Input is uncompressed |
| dout_valid | output | 1 | Rebuilt line present |
| dout_ready | input | 1 | Rebuilt line taken |
| dout_line | output | 512 | Rebuilt line |

## Verification
A new line can enter the compressor or the expander in the very cycle that the line before it leaves, and both paths can do this in the same cycle. A streaming scenario supplies four lines to both inputs on consecutive cycles while keeping both outputs ready. Every cycle is then compared with the model. The expander output must show the line accepted four edges earlier, and the compressor output must show the line accepted on the last edge. A stall scenario then holds each output for several cycles and releases it together with a waiting input, which must be taken on that release edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int FPC_WORD_W = 32;
  localparam int FPC_PFX_W  = 3;
  localparam int FPC_WID_W  = $clog2(FPC_WORD_W + 1);

  typedef enum logic [FPC_PFX_W-1:0] {
    PFX_ZERO   = 3'd0,
    PFX_SE4    = 3'd1,
    PFX_SE8    = 3'd2,
    PFX_SE16   = 3'd3,
    PFX_HPAD   = 3'd4,
    PFX_HSPLIT = 3'd5,
    PFX_REP    = 3'd6,
    PFX_RAW    = 3'd7
  } fpc_pfx_e;

  function automatic logic [FPC_WID_W-1:0] fpc_pfx_width(input logic [FPC_PFX_W-1:0] p);
    case (fpc_pfx_e'(p))
      PFX_ZERO:              return FPC_WID_W'(0);
      PFX_SE4:               return FPC_WID_W'(4);
      PFX_SE8, PFX_REP:      return FPC_WID_W'(8);
      PFX_SE16, PFX_HPAD,
      PFX_HSPLIT:            return FPC_WID_W'(16);
      default:               return FPC_WID_W'(FPC_WORD_W);
    endcase
  endfunction
endpackage

// File: rtl/fpc_word_enc.sv
module fpc_word_enc
  import fpc_pkg::*;
(
  input  logic [FPC_WORD_W-1:0] word_i,
  output logic [FPC_PFX_W-1:0]  pfx_o,
  output logic [FPC_WORD_W-1:0] pay_o,
  output logic [FPC_WID_W-1:0]  wid_o
);
  logic m_zero, m_se4, m_se8, m_se16, m_hpad, m_split, m_rep;

  always_comb begin
    m_zero  = (word_i == '0);
    m_se4   = (word_i == {{28{word_i[3]}}, word_i[3:0]});
    m_se8   = (word_i == {{24{word_i[7]}}, word_i[7:0]});
    m_se16  = (word_i == {{16{word_i[15]}}, word_i[15:0]});
    m_hpad  = (word_i[15:0] == 16'h0);
    m_split = (word_i[31:16] == {{8{word_i[23]}}, word_i[23:16]}) &&
              (word_i[15:0]  == {{8{word_i[7]}},  word_i[7:0]});
    m_rep   = (word_i == {4{word_i[7:0]}});
  end

  // candidates tried in order of kept width, then code value
  always_comb begin
    if (m_zero) begin
      pfx_o = PFX_ZERO;   pay_o = '0;
    end else if (m_se4) begin
      pfx_o = PFX_SE4;    pay_o = {28'h0, word_i[3:0]};
    end else if (m_se8) begin
      pfx_o = PFX_SE8;    pay_o = {24'h0, word_i[7:0]};
    end else if (m_rep) begin
      pfx_o = PFX_REP;    pay_o = {24'h0, word_i[7:0]};
    end else if (m_se16) begin
      pfx_o = PFX_SE16;   pay_o = {16'h0, word_i[15:0]};
    end else if (m_hpad) begin
      pfx_o = PFX_HPAD;   pay_o = {16'h0, word_i[31:16]};
    end else if (m_split) begin
      pfx_o = PFX_HSPLIT; pay_o = {16'h0, word_i[23:16], word_i[7:0]};
    end else begin
      pfx_o = PFX_RAW;    pay_o = word_i;
    end
    wid_o = fpc_pfx_width(pfx_o);
  end
endmodule

// File: rtl/fpc_word_dec.sv
module fpc_word_dec
  import fpc_pkg::*;
(
  input  logic [FPC_PFX_W-1:0]  pfx_i,
  input  logic [FPC_WORD_W-1:0] pay_i,
  output logic [FPC_WORD_W-1:0] word_o
);
  always_comb begin
    case (fpc_pfx_e'(pfx_i))
      PFX_ZERO:   word_o = '0;
      PFX_SE4:    word_o = {{28{pay_i[3]}}, pay_i[3:0]};
      PFX_SE8:    word_o = {{24{pay_i[7]}}, pay_i[7:0]};
      PFX_SE16:   word_o = {{16{pay_i[15]}}, pay_i[15:0]};
      PFX_HPAD:   word_o = {pay_i[15:0], 16'h0};
      PFX_HSPLIT: word_o = {{8{pay_i[15]}}, pay_i[15:8], {8{pay_i[7]}}, pay_i[7:0]};
      PFX_REP:    word_o = {4{pay_i[7:0]}};
      default:    word_o = pay_i;
    endcase
  end
endmodule

// File: rtl/fpc_packer.sv
module fpc_packer
  import fpc_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int SEG_W  = 64,
  parameter int SEGS_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORDS*FPC_WORD_W-1:0] in_line,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WORDS*FPC_WORD_W-1:0] out_data,
  output logic [SEGS_W-1:0]           out_segs,
  output logic                        out_raw
);
  localparam int LINE_W    = WORDS * FPC_WORD_W;
  localparam int HDR_W     = WORDS * FPC_PFX_W;
  localparam int STREAM_W  = HDR_W + LINE_W;
  localparam int CNT_W     = $clog2(STREAM_W + 1);
  localparam int SEG_CNT   = LINE_W / SEG_W;
  localparam int RAW_LIMIT = (SEG_CNT - 1) * SEG_W;

  logic [FPC_PFX_W-1:0]  pfx [WORDS];
  logic [FPC_WORD_W-1:0] pay [WORDS];
  logic [FPC_WID_W-1:0]  wid [WORDS];
  logic [STREAM_W-1:0]   stream;
  logic [CNT_W-1:0]      total;
  logic [SEGS_W-1:0]     segs_c;
  logic                  raw_c;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_enc
    fpc_word_enc u_enc (
      .word_i (in_line[gi*FPC_WORD_W +: FPC_WORD_W]),
      .pfx_o  (pfx[gi]),
      .pay_o  (pay[gi]),
      .wid_o  (wid[gi])
    );
  end

  // codes first, then fields in word order
  always_comb begin
    stream = '0;
    total  = CNT_W'(HDR_W);
    for (int i = 0; i < WORDS; i++) begin
      stream[i*FPC_PFX_W +: FPC_PFX_W] = pfx[i];
      stream = stream | (STREAM_W'(pay[i]) << total);
      total  = total + CNT_W'(wid[i]);
    end
    raw_c  = (total > CNT_W'(RAW_LIMIT));
    segs_c = SEGS_W'((total + SEG_W - 1) / SEG_W);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_raw  <= raw_c;
      out_data <= raw_c ? in_line : stream[LINE_W-1:0];
      out_segs <= raw_c ? SEGS_W'(SEG_CNT) : segs_c;
    end
  end

  AST_SEGS_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_segs >= SEGS_W'(1)) && (out_segs <= SEGS_W'(SEG_CNT))); // R4
  AST_RAW_FULL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_raw) |-> (out_segs == SEGS_W'(SEG_CNT))); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_raw) |-> ((out_data >> (out_segs * SEG_W)) == '0)); // R3
  AST_COUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_segs))); // R8
endmodule

// File: rtl/fpc_unpacker.sv
module fpc_unpacker
  import fpc_pkg::*;
#(
  parameter int WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORDS*FPC_WORD_W-1:0] in_data,
  input  logic                        in_raw,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WORDS*FPC_WORD_W-1:0] out_line
);
  localparam int LINE_W   = WORDS * FPC_WORD_W;
  localparam int HDR_W    = WORDS * FPC_PFX_W;
  localparam int STREAM_W = HDR_W + LINE_W;
  localparam int CNT_W    = $clog2(STREAM_W + 1);

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // stage 1: capture
  logic s1_v, s1_raw;
  logic [LINE_W-1:0] s1_d;
  // stage 2: field offsets
  logic s2_v, s2_raw;
  logic [LINE_W-1:0] s2_d;
  logic [CNT_W-1:0]  off_c [WORDS];
  logic [CNT_W-1:0]  s2_off [WORDS];
  logic [CNT_W-1:0]  acc;
  // stage 3: extracted fields
  logic s3_v, s3_raw;
  logic [LINE_W-1:0]     s3_d;
  logic [FPC_WORD_W-1:0] pay_c [WORDS];
  logic [FPC_WORD_W-1:0] s3_pay [WORDS];
  logic [LINE_W-1:0]     sh;
  // stage 4: expanded words
  logic s4_v, s4_raw;
  logic [LINE_W-1:0] s4_d, s4_line, w_c;

  always_comb begin
    acc = CNT_W'(HDR_W);
    for (int i = 0; i < WORDS; i++) begin
      off_c[i] = acc;
      acc = acc + CNT_W'(fpc_pfx_width(s1_d[i*FPC_PFX_W +: FPC_PFX_W]));
    end
  end

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      sh       = s2_d >> s2_off[i];
      pay_c[i] = sh[FPC_WORD_W-1:0];
    end
  end

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_dec
    fpc_word_dec u_dec (
      .pfx_i  (s3_d[gi*FPC_PFX_W +: FPC_PFX_W]),
      .pay_i  (s3_pay[gi]),
      .word_o (w_c[gi*FPC_WORD_W +: FPC_WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {s1_v, s2_v, s3_v, s4_v, out_valid} <= '0;
    end else if (en) begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      s3_v      <= s2_v;
      s4_v      <= s3_v;
      out_valid <= s4_v;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_d   <= in_data;  s1_raw <= in_raw;
      s2_d   <= s1_d;     s2_raw <= s1_raw;
      s3_d   <= s2_d;     s3_raw <= s2_raw;
      s4_d   <= s3_d;     s4_raw <= s3_raw;
      s4_line <= w_c;
      out_line <= s4_raw ? s4_d : s4_line;
      for (int i = 0; i < WORDS; i++) begin
        s2_off[i] <= off_c[i];
        s3_pay[i] <= pay_c[i];
      end
    end
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line))); // R8
  AST_DIN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

// File: rtl/fpc_line_codec.sv
module fpc_line_codec
  import fpc_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int SEG_W = 64
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       cin_valid,
  output logic                                       cin_ready,
  input  logic [WORDS*FPC_WORD_W-1:0]                cin_line,
  output logic                                       cout_valid,
  input  logic                                       cout_ready,
  output logic [WORDS*FPC_WORD_W-1:0]                cout_data,
  output logic [$clog2(WORDS*FPC_WORD_W/SEG_W+1)-1:0] cout_segs,
  output logic                                       cout_raw,
  input  logic                                       din_valid,
  output logic                                       din_ready,
  input  logic [WORDS*FPC_WORD_W-1:0]                din_data,
  input  logic                                       din_raw,
  output logic                                       dout_valid,
  input  logic                                       dout_ready,
  output logic [WORDS*FPC_WORD_W-1:0]                dout_line
);
  localparam int SEGS_W = $clog2(WORDS * FPC_WORD_W / SEG_W + 1);

  fpc_packer #(.WORDS(WORDS), .SEG_W(SEG_W), .SEGS_W(SEGS_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cin_valid),
    .in_ready  (cin_ready),
    .in_line   (cin_line),
    .out_valid (cout_valid),
    .out_ready (cout_ready),
    .out_data  (cout_data),
    .out_segs  (cout_segs),
    .out_raw   (cout_raw)
  );

  fpc_unpacker #(.WORDS(WORDS)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (din_valid),
    .in_ready  (din_ready),
    .in_data   (din_data),
    .in_raw    (din_raw),
    .out_valid (dout_valid),
    .out_ready (dout_ready),
    .out_line  (dout_line)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!cout_valid && !dout_valid)); // R9
endmodule

// File: tb/tb_fpc_line_codec.sv
module tb_fpc_line_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cin_valid = 0, cout_ready = 1, din_valid = 0, din_raw = 0, dout_ready = 1;
  logic [511:0] cin_line = '0, din_data = '0;
  logic cin_ready, cout_valid, cout_raw, din_ready, dout_valid;
  logic [511:0] cout_data, dout_line;
  logic [3:0] cout_segs;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  fpc_line_codec dut (.*);

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent model of the requirements
  function automatic void m_word(input logic [31:0] w, output logic [2:0] p,
                                 output logic [31:0] d, output int n);
    if (w == 0)                                   begin p = 0; d = 0; n = 0; end
    else if (w == {{28{w[3]}}, w[3:0]})           begin p = 1; d = {28'h0, w[3:0]}; n = 4; end
    else if (w == {{24{w[7]}}, w[7:0]})           begin p = 2; d = {24'h0, w[7:0]}; n = 8; end
    else if (w == {4{w[7:0]}})                    begin p = 6; d = {24'h0, w[7:0]}; n = 8; end
    else if (w == {{16{w[15]}}, w[15:0]})         begin p = 3; d = {16'h0, w[15:0]}; n = 16; end
    else if (w[15:0] == 0)                        begin p = 4; d = {16'h0, w[31:16]}; n = 16; end
    else if (w[31:16] == {{8{w[23]}}, w[23:16]} && w[15:0] == {{8{w[7]}}, w[7:0]})
                                                  begin p = 5; d = {16'h0, w[23:16], w[7:0]}; n = 16; end
    else                                          begin p = 7; d = w; n = 32; end
  endfunction

  function automatic void m_line(input logic [511:0] line, output logic [511:0] data,
                                 output logic [3:0] segs, output logic raw);
    logic [559:0] s; int off; logic [2:0] p; logic [31:0] d; int n;
    s = '0; off = 48;
    for (int i = 0; i < 16; i++) begin
      m_word(line[i*32 +: 32], p, d, n);
      s[i*3 +: 3] = p;
      for (int b = 0; b < n; b++) s[off + b] = d[b];
      off += n;
    end
    if (off > 448) begin raw = 1; data = line; segs = 8; end
    else begin raw = 0; data = s[511:0]; segs = 4'((off + 63) / 64); end
  endfunction

  function automatic logic [31:0] biased_word();
    logic [31:0] r = $urandom;
    case ($urandom % 9)
      0: return 0;
      1: return {{28{r[3]}}, r[3:0]};
      2: return {{24{r[7]}}, r[7:0]};
      3: return {{16{r[15]}}, r[15:0]};
      4: return {r[31:16], 16'h0};
      5: return {{8{r[23]}}, r[23:16], {8{r[7]}}, r[7:0]};
      6: return {4{r[7:0]}};
      default: return r;
    endcase
  endfunction

  // called and returns at a falling edge with the path idle
  task automatic compress_one(input logic [511:0] line, output logic [511:0] data,
                              output logic [3:0] segs, output logic raw);
    cin_line = line; cin_valid = 1; cout_ready = 1;
    @(posedge clk); #1 cin_valid = 0;
    @(negedge clk);
    chk("R8 cout_valid after accept", 512'(cout_valid), 512'(1));
    data = cout_data; segs = cout_segs; raw = cout_raw;
  endtask

  task automatic expand_one(input logic [511:0] data, input logic raw, output logic [511:0] line);
    int lat;
    din_data = data; din_raw = raw; din_valid = 1; dout_ready = 1;
    @(posedge clk); #1 din_valid = 0;
    lat = 1;
    forever begin
      @(negedge clk);
      if (dout_valid || lat > 20) break;
      @(posedge clk); lat++;
    end
    chk("R6 expand latency", 512'(lat), 512'(5));
    line = dout_line;
  endtask

  task automatic full_check(string tag, logic [511:0] line);
    logic [511:0] d, ed, back; logic [3:0] s, es; logic r, er;
    m_line(line, ed, es, er);
    compress_one(line, d, s, r);
    chk({tag, " R3 packed data"}, d, ed);
    chk({tag, " R4 segment count"}, 512'(s), 512'(es));
    chk({tag, " R5 raw flag"}, 512'(r), 512'(er));
    expand_one(d, r, back);
    chk({tag, " R6 round trip"}, back, line);
  endtask

  task automatic t_reset();
    chk("R9 idle after reset", 512'({cin_ready, din_ready, cout_valid, dout_valid}), 512'(4'b1100));
  endtask

  task automatic t_patterns();
    logic [511:0] line, d; logic [3:0] s; logic r;
    // hand-built: word0=5 only -> code 1 at bits 2:0, field 0101 at bit 48, 52 bits total
    line = 512'h5;
    compress_one(line, d, s, r);
    chk("R3 hand layout", d, (512'h5 << 48) | 512'h1);
    chk("R4 one segment at 52 bits", 512'(s), 512'(1));
    // exactly 64 bits -> 1 segment; 68 bits -> 2 segments
    compress_one(512'h1234, d, s, r);
    chk("R4 64 bits one segment", 512'(s), 512'(1));
    compress_one(512'h1234 | (512'h3 << 32), d, s, r);
    chk("R4 68 bits two segments", 512'(s), 512'(2));
    for (int k = 0; k < 8; k++) begin
      line = '0;
      for (int i = 0; i < 16; i++) begin
        case (k)
          0: line[i*32 +: 32] = 0;
          1: line[i*32 +: 32] = 32'hFFFF_FFF9;
          2: line[i*32 +: 32] = 32'h0000_0042 + i;
          3: line[i*32 +: 32] = 32'hFFFF_8001 + i;
          4: line[i*32 +: 32] = {16'hA5C3 + 16'(i), 16'h0};
          5: line[i*32 +: 32] = 32'h0012_FF90;
          6: line[i*32 +: 32] = {4{8'h3C + 8'(i)}};
          default: line[i*32 +: 32] = 32'h1357_9BDF ^ (i << 20);
        endcase
      end
      full_check($sformatf("R1 kind %0d", k), line);
    end
  endtask

  task automatic t_priority();
    logic [511:0] line, d; logic [3:0] s; logic r; logic [47:0] ep;
    line = '0;
    line[0*32 +: 32] = 32'h0;        line[1*32 +: 32] = 32'hFFFF_FFFF;
    line[2*32 +: 32] = 32'hFFFF_FF80; line[3*32 +: 32] = 32'h7F7F_7F7F;
    line[4*32 +: 32] = 32'h0001_0000; line[5*32 +: 32] = 32'h0000_0080;
    line[6*32 +: 32] = 32'h1234_0000; line[7*32 +: 32] = 32'hFF80_007F;
    line[8*32 +: 32] = 32'hDEAD_BEEF;
    ep = '0;
    ep[2:0] = 0; ep[5:3] = 1; ep[8:6] = 2; ep[11:9] = 6; ep[14:12] = 4;
    ep[17:15] = 3; ep[20:18] = 4; ep[23:21] = 5; ep[26:24] = 7;
    compress_one(line, d, s, r);
    chk("R2 chosen codes", 512'(d[47:0]), 512'(ep));
    full_check("R2 overlap line", line);
  endtask

  task automatic t_raw();
    logic [511:0] line;
    // 12 full words + one 16-bit field = 448 bits -> still packed, 7 segments
    line = '0;
    for (int i = 0; i < 12; i++) line[i*32 +: 32] = 32'h9ABC_DEF1 + i * 32'h0101_0000;
    line[12*32 +: 32] = 32'h0000_4321;
    full_check("R5 448 bits packed", line);
    // add a 4-bit field -> 452 bits -> stored raw
    line[13*32 +: 32] = 32'h0000_0006;
    full_check("R5 452 bits raw", line);
    for (int i = 0; i < 16; i++) line[i*32 +: 32] = $urandom | 32'h4000_0100;
    full_check("R5 random raw", line);
  endtask

  task automatic t_expand_raw();
    logic [511:0] junk, back;
    for (int i = 0; i < 16; i++) junk[i*32 +: 32] = $urandom;
    expand_one(junk, 1'b1, back);
    chk("R7 raw passes through", back, junk);
  endtask

  task automatic t_backpressure();
    logic [511:0] a, b, ea, eb, hold; logic [3:0] s; logic r;
    a = 512'h77 << 96; b = 512'hFFFF_FFFE;
    m_line(a, ea, s, r); m_line(b, eb, s, r);
    cout_ready = 0; cin_line = a; cin_valid = 1;
    @(posedge clk); #1 cin_line = b;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 cout held", cout_data, ea);
      chk("R8 cin blocked", 512'({cout_valid, cin_ready}), 512'(2'b10));
      @(posedge clk);
    end
    @(negedge clk); cout_ready = 1;
    @(posedge clk); #1 cin_valid = 0;
    @(negedge clk);
    chk("R8 waiting line taken", cout_data, eb);
    @(posedge clk); @(negedge clk);
    chk("R8 cout drained", 512'(cout_valid), 512'(0));
    // expander stall
    dout_ready = 0; din_data = ea; din_raw = 0; din_valid = 1;
    @(posedge clk); #1 din_valid = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    hold = dout_line;
    chk("R8 dout valid under stall", 512'(dout_valid), 512'(1));
    chk("R6 stalled result", hold, a);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 dout held", dout_line, hold);
      chk("R8 din blocked", 512'({dout_valid, din_ready}), 512'(2'b10));
    end
    dout_ready = 1;
    @(posedge clk); @(negedge clk);
    chk("R8 dout drained", 512'(dout_valid), 512'(0));
  endtask

  task automatic t_stream();
    logic [511:0] L [4], E [4];
    logic [3:0] S [4]; logic R [4];
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 16; i++) L[j][i*32 +: 32] = biased_word();
      m_line(L[j], E[j], S[j], R[j]);
    end
    cout_ready = 1; dout_ready = 1;
    for (int c = 0; c < 10; c++) begin
      cin_valid = (c < 4); din_valid = (c < 4);
      if (c < 4) begin cin_line = L[c]; din_data = E[c]; din_raw = R[c]; end
      @(posedge clk); @(negedge clk);
      if (c < 4) begin
        chk("R10 cout streaming", cout_data, E[c]);
        chk("R10 segs streaming", 512'(cout_segs), 512'(S[c]));
      end else chk("R10 cout idle", 512'(cout_valid), 512'(0));
      if (c >= 4 && c < 8) chk("R10 dout streaming", dout_line, L[c-4]);
      chk("R10 dout valid timing", 512'(dout_valid), 512'(c >= 4 && c < 8));
    end
    cin_valid = 0; din_valid = 0;
  endtask

  task automatic t_random();
    logic [511:0] line, d, back; logic [3:0] s; logic r;
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 16; i++) line[i*32 +: 32] = biased_word();
      full_check("R6 random", line);
      compress_one(line, d, s, r);
      expand_one(d, r, back);
      chk("R6 dut round trip", back, line);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_priority();
    t_raw();
    t_expand_raw();
    t_backpressure();
    t_stream();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule